// File: doc/BRIEF.md
# Input Clock Frequency Monitor

This block watches one input clock and decides whether its frequency has strayed from a reference clock. The monitored clock and every candidate reference arrive as single-cycle edge pulses that have already been synchronized into the system clock domain. A selector picks one of five references as the zero-offset standard. Two measurements run at the same time on that standard.

The precise measurement counts monitored edges over a long gate of reference ticks. It compares the count against an expected count, with a separate threshold for entering and for leaving the out-of-frequency state. Thresholds are given in sixteenths of a part per million. The fast measurement uses a gate 256 times shorter and compares each window's count with the previous one. A sudden step of more than 4000 ppm raises a flag without waiting for the long gate.

Each check has its own enable. The live flag is their masked OR, and a sticky copy latches every assertion until software clears it. The control and status pins are plain levels and pulses. The block has no streaming interface, so it has no back-pressure.

Top module: `freq_monitor`

## Requirements
- R1: Reset drives both `oof_live` and `oof_sticky` to 1. `oof_live` stays 1 until the first complete precise window has been evaluated, whatever the enables are.
- R2: `ref_sel` picks the reference tick source:
  - 0 selects bit 0, the dedicated reference.
  - 1, 2 and 3 select bits 1 to 3, the main inputs.
  - 4 selects bit 4, the crystal clock.
  - 5 to 7 fall back to bit 0.
  
  A precise window spans `gate_len` ticks of the selected reference. Its count is the number of monitored edges in all cycles of the window.
- R3: From the in-frequency state, the precise check declares out-of-frequency when |N−E|·16,000,000 > E·`set_thr`. Here N is the window count, E is `exp_cnt`, and both thresholds are in 1/16 ppm units.
- R4: From the out-of-frequency state, the precise check returns to in-frequency only when |N−E|·16,000,000 ≤ E·`clr_thr`. A count between the two limits keeps the previous state. The precise state before the first window counts as out-of-frequency.
- R5: The precise check is symmetric. A count above E by the same margin is flagged exactly as a count below it.
- R6: The fast check uses a gate of `gate_len`>>8 reference ticks, with a minimum of 1. It flags when |C−P|·16,000,000 > P·64,000, where C is the current fast count and P is the previous one. Its first window never flags. A steady input clears the flag on the next window.
- R7: After start-up, `oof_live` is the OR of the precise result gated by `prec_en` and the fast result gated by `fast_en`. A disabled check has no effect on either flag.
- R8: `oof_sticky` becomes 1 one cycle after any cycle with `oof_live` at 1. It clears only on a `sticky_clr` pulse while `oof_live` is 0. A clear that arrives while `oof_live` is 1 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_sel | input | 3 | Zero-offset reference select |
| ref_ticks | input | 5 | Edge pulses of the candidate references |
| mon_tick | input | 1 | Edge pulse of the monitored clock |
| gate_len | input | 20 | Precise gate length in reference ticks |
| exp_cnt | input | 20 | Expected monitored count per precise gate |
| set_thr | input | 13 | Entry threshold, 1/16 ppm units |
| clr_thr | input | 13 | Exit threshold, 1/16 ppm units |
| prec_en | input | 1 | Precise check enable |
| fast_en | input | 1 | Fast check enable |
| sticky_clr | input | 1 | Clear pulse for the sticky flag |
| oof_live | output | 1 | Current out-of-frequency state |
| oof_sticky | output | 1 | Latched out-of-frequency state |

## Verification
A window's verdict reaches `oof_live` three cycles after the reference tick that closes the window. The verdict reaches `oof_sticky` one cycle after that, and an enable change shows on `oof_live` one cycle later. Every stimulus change is therefore held for at least two full precise windows plus margin before the flag is sampled. This keeps the sampled result free of any window that mixes the old and new stimulus. Drop patterns divide the gate exactly, so each pure window holds a known count. Sticky checks sample a few cycles after a one-cycle clear pulse.

// File: rtl/freq_monitor_pkg.sv
package freq_monitor_pkg;
  // one ppm scaled into threshold units (1/16 ppm)
  localparam int unsigned SUB_PPM   = 16;
  localparam int unsigned PPM_SCALE = 1_000_000 * SUB_PPM;
endpackage

// File: rtl/freq_monitor_refsel.sv
module freq_monitor_refsel #(
  parameter int N_REF = 5,
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] ref_sel,
  input  logic [N_REF-1:0] ref_ticks,
  output logic             ref_tick
);
  // codes outside the populated range fall back to source 0
  always_comb begin
    ref_tick = ref_ticks[0];
    for (int i = 1; i < N_REF; i++) begin
      if (ref_sel == SEL_W'(i)) ref_tick = ref_ticks[i];
    end
  end
endmodule

// File: rtl/freq_monitor_gate.sv
module freq_monitor_gate #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             mon_tick,
  input  logic [CNT_W-1:0] gate_len,
  output logic             done,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] rcnt, mcnt, lim;
  logic             close;

  always_comb begin
    lim   = (gate_len == '0) ? '0 : gate_len - CNT_W'(1);
    close = ref_tick && (rcnt >= lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcnt  <= '0;
      mcnt  <= '0;
      done  <= 1'b0;
      count <= '0;
    end else begin
      done <= close;
      if (ref_tick) rcnt <= close ? '0 : rcnt + CNT_W'(1);
      if (close) begin
        count <= (mcnt == '1) ? mcnt : mcnt + CNT_W'(mon_tick);
        mcnt  <= '0;
      end else if (mon_tick && mcnt != '1) begin
        mcnt <= mcnt + CNT_W'(1);
      end
    end
  end

  // a reported window leaves the tick counter restarted
  assert_window_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rcnt == '0));
endmodule

// File: rtl/freq_monitor_precise.sv
module freq_monitor_precise #(
  parameter int CNT_W = 20,
  parameter int THR_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] exp_cnt,
  input  logic [THR_W-1:0] set_thr,
  input  logic [THR_W-1:0] clr_thr,
  output logic             oof,
  output logic             primed
);
  localparam int PROD_W = CNT_W + 26;
  localparam logic [PROD_W-1:0] SCALE = PROD_W'(freq_monitor_pkg::PPM_SCALE);

  logic [CNT_W-1:0]  diff;
  logic [PROD_W-1:0] err, set_lim, clr_lim;

  always_comb begin
    diff    = (count >= exp_cnt) ? count - exp_cnt : exp_cnt - count;
    err     = PROD_W'(diff) * SCALE;
    set_lim = PROD_W'(exp_cnt) * PROD_W'(set_thr);
    clr_lim = PROD_W'(exp_cnt) * PROD_W'(clr_thr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oof    <= 1'b1;
      primed <= 1'b0;
    end else if (done) begin
      primed <= 1'b1;
      oof    <= oof ? (err > clr_lim) : (err > set_lim);
    end
  end

  assert_hold_between_windows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(oof));
  assert_primed_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed);
endmodule

// File: rtl/freq_monitor_fast.sv
module freq_monitor_fast #(
  parameter int CNT_W    = 20,
  parameter int FAST_PPM = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [CNT_W-1:0] count,
  output logic             oof
);
  localparam int PROD_W = CNT_W + 26;
  localparam logic [PROD_W-1:0] SCALE = PROD_W'(freq_monitor_pkg::PPM_SCALE);
  localparam logic [PROD_W-1:0] STEP  = PROD_W'(FAST_PPM * freq_monitor_pkg::SUB_PPM);

  logic [CNT_W-1:0]  prev, delta;
  logic              have_prev;
  logic [PROD_W-1:0] err, lim;

  always_comb begin
    delta = (count >= prev) ? count - prev : prev - count;
    err   = PROD_W'(delta) * SCALE;
    lim   = PROD_W'(prev) * STEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev      <= '0;
      have_prev <= 1'b0;
      oof       <= 1'b0;
    end else if (done) begin
      prev      <= count;
      have_prev <= 1'b1;
      oof       <= have_prev && (err > lim);
    end
  end

  assert_first_window_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !have_prev) |=> !oof);
endmodule

// File: rtl/freq_monitor.sv
module freq_monitor #(
  parameter int N_REF      = 5,
  parameter int SEL_W      = 3,
  parameter int CNT_W      = 20,
  parameter int THR_W      = 13,
  parameter int FAST_SHIFT = 8,
  parameter int FAST_PPM   = 4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ref_sel,
  input  logic [N_REF-1:0] ref_ticks,
  input  logic             mon_tick,
  input  logic [CNT_W-1:0] gate_len,
  input  logic [CNT_W-1:0] exp_cnt,
  input  logic [THR_W-1:0] set_thr,
  input  logic [THR_W-1:0] clr_thr,
  input  logic             prec_en,
  input  logic             fast_en,
  input  logic             sticky_clr,
  output logic             oof_live,
  output logic             oof_sticky
);
  logic             ref_tick;
  logic [CNT_W-1:0] fast_raw, fast_gate;
  logic             p_done, f_done, p_oof, f_oof, primed;
  logic [CNT_W-1:0] p_count, f_count;

  always_comb begin
    fast_raw  = gate_len >> FAST_SHIFT;
    fast_gate = (fast_raw == '0) ? CNT_W'(1) : fast_raw;
  end

  freq_monitor_refsel #(.N_REF(N_REF), .SEL_W(SEL_W)) refsel_i (
    .ref_sel(ref_sel), .ref_ticks(ref_ticks), .ref_tick(ref_tick));

  freq_monitor_gate #(.CNT_W(CNT_W)) prec_gate_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .mon_tick(mon_tick),
    .gate_len(gate_len), .done(p_done), .count(p_count));

  freq_monitor_gate #(.CNT_W(CNT_W)) fast_gate_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .mon_tick(mon_tick),
    .gate_len(fast_gate), .done(f_done), .count(f_count));

  freq_monitor_precise #(.CNT_W(CNT_W), .THR_W(THR_W)) prec_i (
    .clk(clk), .rst_n(rst_n), .done(p_done), .count(p_count),
    .exp_cnt(exp_cnt), .set_thr(set_thr), .clr_thr(clr_thr),
    .oof(p_oof), .primed(primed));

  freq_monitor_fast #(.CNT_W(CNT_W), .FAST_PPM(FAST_PPM)) fast_i (
    .clk(clk), .rst_n(rst_n), .done(f_done), .count(f_count), .oof(f_oof));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oof_live   <= 1'b1;
      oof_sticky <= 1'b1;
    end else begin
      oof_live <= !primed || (prec_en && p_oof) || (fast_en && f_oof);
      if (oof_live)        oof_sticky <= 1'b1;
      else if (sticky_clr) oof_sticky <= 1'b0;
    end
  end

  assert_startup_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> oof_live);
  assert_both_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !prec_en && !fast_en) |=> !oof_live);
  assert_sticky_catches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oof_live |=> oof_sticky);
  assert_sticky_clear_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oof_sticky) |-> $past(sticky_clr));
endmodule

// File: tb/freq_monitor_tb_top.sv
module freq_monitor_tb_top;
  localparam int CNT_W = 20;
  localparam int THR_W = 13;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic [2:0]       ref_sel = '0;
  logic [4:0]       ref_ticks = '0;
  logic             mon_tick = 1'b0;
  logic [CNT_W-1:0] gate_len = CNT_W'(4096);
  logic [CNT_W-1:0] exp_cnt = CNT_W'(4096);
  logic [THR_W-1:0] set_thr = THR_W'(8000);
  logic [THR_W-1:0] clr_thr = THR_W'(4000);
  logic             prec_en = 1'b0, fast_en = 1'b0, sticky_clr = 1'b0;
  logic             oof_live, oof_sticky;

  freq_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .ref_ticks(ref_ticks),
    .mon_tick(mon_tick), .gate_len(gate_len), .exp_cnt(exp_cnt),
    .set_thr(set_thr), .clr_thr(clr_thr), .prec_en(prec_en),
    .fast_en(fast_en), .sticky_clr(sticky_clr),
    .oof_live(oof_live), .oof_sticky(oof_sticky));

  // stimulus generator: ref bits 0,2,3 tick every cycle, bits 1 and 4 every
  // other cycle; the monitored clock drops one edge every drop_p cycles
  int cyc = 0;
  int drop_p = 0;
  initial forever begin
    @(negedge clk);
    cyc++;
    mon_tick  = (drop_p == 0) ? 1'b1 : ((cyc % drop_p) != 0);
    ref_ticks = {cyc[0], 1'b1, 1'b1, cyc[0], 1'b1};
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic act, input logic expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, expv);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk) sticky_clr = 1'b1;
    @(negedge clk) sticky_clr = 1'b0;
    wait_cyc(3);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  typedef struct packed {
    logic [2:0]  sel;
    logic [15:0] gate;
    logic [15:0] expc;
    logic        pen;
    logic        fen;
    logic [15:0] drop;
    logic [15:0] hold;
    logic        live;
    logic [3:0]  req;
  } vec_t;

  // E=4096: set 8000 trips at |diff|>=3, clear 4000 releases at |diff|<=1
  localparam vec_t VECS [13] = '{
    '{3'd0, 16'd4096, 16'd4096, 1'b1, 1'b0, 16'd0,    16'd9000, 1'b0, 4'd3}, // R3 nominal
    '{3'd0, 16'd4096, 16'd4096, 1'b1, 1'b0, 16'd1024, 16'd9000, 1'b1, 4'd3}, // R3 -4 counts
    '{3'd0, 16'd4096, 16'd4096, 1'b1, 1'b0, 16'd2048, 16'd9000, 1'b1, 4'd4}, // R4 -2 holds set
    '{3'd0, 16'd4096, 16'd4096, 1'b1, 1'b0, 16'd4096, 16'd9000, 1'b0, 4'd4}, // R4 -1 clears
    '{3'd0, 16'd4096, 16'd4096, 1'b1, 1'b0, 16'd2048, 16'd9000, 1'b0, 4'd4}, // R4 -2 stays clear
    '{3'd0, 16'd4096, 16'd4096, 1'b1, 1'b0, 16'd1024, 16'd9000, 1'b1, 4'd3}, // R3
    '{3'd0, 16'd4096, 16'd4096, 1'b1, 1'b0, 16'd0,    16'd9000, 1'b0, 4'd4}, // R4
    '{3'd0, 16'd4096, 16'd4092, 1'b1, 1'b0, 16'd0,    16'd9000, 1'b1, 4'd5}, // R5 +4 counts
    '{3'd0, 16'd4096, 16'd4092, 1'b0, 1'b1, 16'd0,    16'd200,  1'b0, 4'd7}, // R7 precise masked
    '{3'd1, 16'd2048, 16'd4096, 1'b1, 1'b0, 16'd0,    16'd9000, 1'b0, 4'd2}, // R2 half-rate main input
    '{3'd0, 16'd2048, 16'd4096, 1'b1, 1'b0, 16'd0,    16'd9000, 1'b1, 4'd2}, // R2 full-rate ref
    '{3'd4, 16'd2048, 16'd4096, 1'b1, 1'b0, 16'd0,    16'd9000, 1'b0, 4'd2}, // R2 crystal
    '{3'd7, 16'd2048, 16'd4096, 1'b1, 1'b0, 16'd0,    16'd9000, 1'b1, 4'd2}  // R2 fallback to 0
  };

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_cyc(5);
    chk("R1 live in reset", oof_live, 1'b1);
    chk("R1 sticky in reset", oof_sticky, 1'b1);
    rst_n = 1'b1;
    wait_cyc(3000);
    chk("R1 live before first window", oof_live, 1'b1);
    wait_cyc(1300);
    chk("R1 live after first window", oof_live, 1'b0);
    chk("R8 sticky held from start-up", oof_sticky, 1'b1);
    pulse_clr();
    chk("R8 sticky cleared", oof_sticky, 1'b0);

    for (int i = 0; i < 13; i++) begin
      ref_sel  = VECS[i].sel;
      gate_len = CNT_W'(VECS[i].gate);
      exp_cnt  = CNT_W'(VECS[i].expc);
      prec_en  = VECS[i].pen;
      fast_en  = VECS[i].fen;
      drop_p   = int'(VECS[i].drop);
      wait_cyc(int'(VECS[i].hold));
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), oof_live, VECS[i].live);
    end

    // back to nominal, then sticky clear with live low
    ref_sel = 3'd0; gate_len = CNT_W'(4096); exp_cnt = CNT_W'(4096);
    prec_en = 1'b1; fast_en = 1'b0; drop_p = 0;
    wait_cyc(9000);
    chk("R4 nominal again", oof_live, 1'b0);
    pulse_clr();
    chk("R8 sticky clear", oof_sticky, 1'b0);

    // fast step: every-cycle to every-other-cycle edges
    prec_en = 1'b0; fast_en = 1'b1;
    wait_cyc(100);
    chk("R6 steady input", oof_live, 1'b0);
    chk("R6 sticky quiet", oof_sticky, 1'b0);
    drop_p = 2;
    wait_cyc(200);
    chk("R6 step latched", oof_sticky, 1'b1);
    chk("R6 clears when steady", oof_live, 1'b0);
    pulse_clr();
    chk("R8 clear after fast step", oof_sticky, 1'b0);

    // fast disabled: the same step must leave both flags low
    fast_en = 1'b0;
    drop_p = 0;
    wait_cyc(200);
    chk("R7 fast masked sticky", oof_sticky, 1'b0);
    chk("R7 fast masked live", oof_live, 1'b0);

    // clear request while live is high
    prec_en = 1'b1; drop_p = 1024;
    wait_cyc(9000);
    chk("R3 offset flagged", oof_live, 1'b1);
    pulse_clr();
    chk("R8 clear ignored while live", oof_sticky, 1'b1);

    finish_run();
  end
endmodule